// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag and Routing Controller

This block is the interrupt front end of a real-time clock. Two event inputs come in as single-cycle strobes: one from the time-of-day alarm comparator and one from the watchdog countdown timer. Each event sets a sticky flag in an 8-bit control register. A per-source mask decides whether a set flag drives a pin. A swap bit picks which of the two pins carries which source. The pin that is modelled as open-drain (`intp_drive_low`) can only pull low. The other pin (`intb_oe`/`intb_data`) has a programmable active level.

Flags are not cleared by writing to the control register. A flag clears when software reads or writes one of the registers that belong to its source.

Each pin has its own state machine with four states:

- `PIN_IDLE`: the pin is quiet.
- `PIN_LEVEL`: the pin follows the request in level mode.
- `PIN_PULSE`: the pin drives a pulse of fixed length.
- `PIN_HOLD`: the pulse has ended and the pin waits for the request to drop.

The transitions are:

- IDLE→LEVEL when a request appears with pulse mode off.
- IDLE→PULSE when a request appears with pulse mode on.
- LEVEL→IDLE when the request drops.
- PULSE→PULSE while the countdown is not zero.
- PULSE→HOLD when the countdown ends with the request still present.
- PULSE→IDLE when the countdown ends with the request gone.
- HOLD→IDLE when the request drops.

A request is a flag that is set and not masked, after the swap routing. The pulse mode is sampled only when the machine leaves IDLE.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, `intp_drive_low` is 0, `intb_oe` is 0 and `intb_data` is 0.
- R2: The control register sits at address 0x0B. `reg_rdata` returns it combinationally whenever `reg_addr` is 0x0B and returns 0 at any other address. The bit layout is: bit7 transfer enable (stored only), bit6 swap, bit5 INTB active level, bit4 pulse mode, bit3 watchdog mask, bit2 alarm mask, bit1 watchdog flag, bit0 alarm flag. A write updates bits 7..2 at the next edge. Writes to bits 1..0 are ignored.
- R3: With bit6=1, the open-drain pin carries the alarm and INTB carries the watchdog. With bit6=0, the assignment is reversed.
- R4: While INTB is active, `intb_oe`=1 and `intb_data` equals bit5. While INTB is inactive, both are 0. The open-drain pin only signals by `intp_drive_low`=1.
- R5: A `wd_event` sets bit1 and a `tod_event` sets bit0 at the next edge, whatever the masks are. An event wins over a clearing access in the same cycle.
- R6: A read or a write at address 0x0C or 0x0D clears bit1 at the next edge. Accesses at other addresses leave bit1 unchanged.
- R7: A read or a write at address 0x03, 0x05 or 0x07 clears bit0 at the next edge.
- R8: In level mode (bit4=0), a pin becomes active on the second edge after its event and stays active while the flag is set and unmasked. It goes inactive one edge after the flag clears or the mask sets.
- R9: In pulse mode (bit4=1), a pin becomes active on the second edge after its event and stays active for exactly PULSE_CYC cycles. Further events while the flag stays set neither extend the pulse nor start a new one. A new pulse needs the flag to clear and set again.
- R10: A mask bit of 1 (bit3 for the watchdog, bit2 for the alarm) keeps that source off both pins. Its flag still sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used only for flag clearing) |
| reg_addr | input | ADDR_W (6) | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Control register readback at address 0x0B, else 0 |
| tod_event | input | 1 | Time-of-day alarm match strobe |
| wd_event | input | 1 | Watchdog countdown time-out strobe |
| intp_drive_low | output | 1 | Open-drain pin pull-down enable |
| intb_oe | output | 1 | INTB output enable |
| intb_data | output | 1 | INTB driven level |

## Verification
A wrong flag bit shows up on `reg_rdata` in the cycle after the event or the access. It also shows on the pin one cycle after that. A pin machine stuck in the wrong state appears as a pin that misses its second-edge activation or that holds past its expected release. A wrong pulse counter shows as a pulse one cycle long or short, or as a pulse that restarts when a repeated event arrives. Each of these is visible within PULSE_CYC+2 cycles of the stimulus.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    // Field order is fixed: software decodes these bit positions.
    typedef struct packed {
        logic te;
        logic swap;
        logic intb_pol;
        logic pulse_mode;
        logic wd_mask;
        logic tod_mask;
        logic wd_flag;
        logic tod_flag;
    } ctl_reg_t;

    typedef enum logic [1:0] {
        PIN_IDLE,
        PIN_LEVEL,
        PIN_PULSE,
        PIN_HOLD
    } pin_state_e;

    localparam int NUM_PINS = 2;
    localparam int PIN_OD   = 0;
    localparam int PIN_B    = 1;

endpackage

// File: rtl/rtc_irq_regs.sv
module rtc_irq_regs
    import rtc_irq_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int CTL_ADDR = 11,
    parameter int TOD_A0   = 3,
    parameter int TOD_A1   = 5,
    parameter int TOD_A2   = 7,
    parameter int WD_A0    = 12,
    parameter int WD_A1    = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              tod_event,
    input  logic              wd_event,
    output ctl_reg_t          ctl,
    output logic [7:0]        reg_rdata
);

    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTL_ADDR);
    localparam logic [ADDR_W-1:0] A_T0  = ADDR_W'(TOD_A0);
    localparam logic [ADDR_W-1:0] A_T1  = ADDR_W'(TOD_A1);
    localparam logic [ADDR_W-1:0] A_T2  = ADDR_W'(TOD_A2);
    localparam logic [ADDR_W-1:0] A_W0  = ADDR_W'(WD_A0);
    localparam logic [ADDR_W-1:0] A_W1  = ADDR_W'(WD_A1);

    ctl_reg_t ctl_q;
    logic     access;
    logic     tod_hit;
    logic     wd_hit;
    logic     unused_wbits;

    assign access  = reg_rd | reg_wr;
    assign tod_hit = access && (reg_addr == A_T0 || reg_addr == A_T1 || reg_addr == A_T2);
    assign wd_hit  = access && (reg_addr == A_W0 || reg_addr == A_W1);
    assign unused_wbits = ^reg_wdata[1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            if (reg_wr && reg_addr == A_CTL) begin
                ctl_q[7:2] <= reg_wdata[7:2];
            end
            ctl_q.tod_flag <= tod_event | (ctl_q.tod_flag & ~tod_hit);
            ctl_q.wd_flag  <= wd_event  | (ctl_q.wd_flag  & ~wd_hit);
        end
    end

    assign ctl       = ctl_q;
    assign reg_rdata = (reg_addr == A_CTL) ? ctl_q : 8'h00;

    a_r5_wd_set: assert property (@(posedge clk) disable iff (!rst_n)
        wd_event |=> ctl_q.wd_flag);
    a_r5_tod_set: assert property (@(posedge clk) disable iff (!rst_n)
        tod_event |=> ctl_q.tod_flag);
    a_r6_wd_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_hit && !wd_event) |=> !ctl_q.wd_flag);
    a_r7_tod_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (tod_hit && !tod_event) |=> !ctl_q.tod_flag);

endmodule

// File: rtl/rtc_irq_pin.sv
module rtc_irq_pin
    import rtc_irq_pkg::*;
#(
    parameter int PULSE_CYC = 375000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic pulse_mode,
    output logic active
);

    localparam int CNT_W = $clog2(PULSE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYC - 1);

    pin_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= PIN_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            PIN_IDLE: begin
                if (req && pulse_mode) begin
                    st_d  = PIN_PULSE;
                    cnt_d = CNT_LOAD;
                end else if (req) begin
                    st_d = PIN_LEVEL;
                end
            end
            PIN_LEVEL: begin
                if (!req) st_d = PIN_IDLE;
            end
            PIN_PULSE: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - CNT_W'(1);
                end else begin
                    st_d = req ? PIN_HOLD : PIN_IDLE;
                end
            end
            PIN_HOLD: begin
                if (!req) st_d = PIN_IDLE;
            end
        endcase
    end

    always_comb begin
        active = (st_q == PIN_LEVEL) || (st_q == PIN_PULSE);
    end

    a_r8_level_release: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PIN_LEVEL && !req) |=> (st_q == PIN_IDLE));
    a_r9_pulse_count: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PIN_PULSE && cnt_q != '0) |=> (st_q == PIN_PULSE && cnt_q == $past(cnt_q) - CNT_W'(1)));
    a_r9_pulse_end: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PIN_PULSE && cnt_q == '0) |=> (st_q != PIN_PULSE));

endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int PULSE_CYC = 375000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              tod_event,
    input  logic              wd_event,
    output logic              intp_drive_low,
    output logic              intb_oe,
    output logic              intb_data
);

    ctl_reg_t            ctl;
    logic                tod_req;
    logic                wd_req;
    logic [NUM_PINS-1:0] pin_req;
    logic [NUM_PINS-1:0] pin_act;

    rtc_irq_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .tod_event (tod_event),
        .wd_event  (wd_event),
        .ctl       (ctl),
        .reg_rdata (reg_rdata)
    );

    assign tod_req = ctl.tod_flag & ~ctl.tod_mask;
    assign wd_req  = ctl.wd_flag  & ~ctl.wd_mask;

    assign pin_req[PIN_OD] = ctl.swap ? tod_req : wd_req;
    assign pin_req[PIN_B]  = ctl.swap ? wd_req  : tod_req;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        rtc_irq_pin #(.PULSE_CYC(PULSE_CYC)) pin_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .req        (pin_req[p]),
            .pulse_mode (ctl.pulse_mode),
            .active     (pin_act[p])
        );
    end

    assign intp_drive_low = pin_act[PIN_OD];
    assign intb_oe        = pin_act[PIN_B];
    assign intb_data      = pin_act[PIN_B] & ctl.intb_pol;

    a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.tod_mask && ctl.wd_mask && !ctl.pulse_mode && $past(ctl.tod_mask && ctl.wd_mask))
        |-> !(intp_drive_low || intb_oe));

endmodule

// File: tb/rtc_irq_ctrl_tb_top.sv
module rtc_irq_ctrl_tb_top;

    localparam int PW = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [5:0] reg_addr = 6'h0B;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       tod_event = 1'b0;
    logic       wd_event = 1'b0;
    logic       intp_drive_low;
    logic       intb_oe;
    logic       intb_data;

    int  n_checks = 0;
    int  n_err = 0;
    bit  done = 1'b0;

    typedef struct {
        string      tag;
        logic [10:0] exp;
    } item_t;
    item_t exp_q[$];

    always #4 clk = ~clk;

    rtc_irq_ctrl #(.ADDR_W(6), .PULSE_CYC(PW)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_wr         (reg_wr),
        .reg_rd         (reg_rd),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .tod_event      (tod_event),
        .wd_event       (wd_event),
        .intp_drive_low (intp_drive_low),
        .intb_oe        (intb_oe),
        .intb_data      (intb_data)
    );

    // Monitor: pops expected items and compares against the ports.
    initial begin
        forever begin
            item_t it;
            logic [10:0] act;
            wait (exp_q.size() != 0);
            it  = exp_q.pop_front();
            act = {intp_drive_low, intb_oe, intb_data, reg_rdata};
            n_checks++;
            if (act !== it.exp) begin
                n_err++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic expect_st(string tag, logic p, logic oe, logic d, logic [7:0] rd);
        #1;
        exp_q.push_back('{tag, {p, oe, d, rd}});
    endtask

    task automatic wr_reg(logic [5:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 6'h0B;
    endtask

    task automatic rd_reg(logic [5:0] a);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0; reg_addr = 6'h0B;
    endtask

    task automatic fire(bit tod);
        @(negedge clk);
        if (tod) tod_event = 1'b1; else wd_event = 1'b1;
        @(negedge clk);
        tod_event = 1'b0; wd_event = 1'b0;
    endtask

    task automatic summary();
        wait (exp_q.size() == 0);
        #1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_st("R1 reset state", 0, 0, 0, 8'h00);

        wr_reg(6'h0B, 8'hFF);
        expect_st("R2 flag bits read-only", 0, 0, 0, 8'hFC);
        wr_reg(6'h0B, 8'h40);
        expect_st("R2 write readback", 0, 0, 0, 8'h40);

        // Level mode, swap=1: alarm on open-drain pin
        fire(1'b1);
        expect_st("R5 alarm flag set, R8 pin not yet", 0, 0, 0, 8'h41);
        @(negedge clk);
        expect_st("R3 R8 alarm on open-drain pin", 1, 0, 0, 8'h41);
        rd_reg(6'h05);
        expect_st("R7 alarm flag cleared by read", 1, 0, 0, 8'h40);
        @(negedge clk);
        expect_st("R8 level release after clear", 0, 0, 0, 8'h40);

        fire(1'b0);
        expect_st("R5 watchdog flag set", 0, 0, 0, 8'h42);
        @(negedge clk);
        expect_st("R3 R4 watchdog on INTB active low", 0, 1, 0, 8'h42);
        wr_reg(6'h0B, 8'h60);
        expect_st("R4 INTB active high", 0, 1, 1, 8'h62);
        wr_reg(6'h0B, 8'h68);
        expect_st("R10 mask set, pin one more cycle", 0, 1, 1, 8'h6A);
        @(negedge clk);
        expect_st("R10 R8 masked pin released", 0, 0, 0, 8'h6A);

        wr_reg(6'h0A, 8'h00);
        expect_st("R6 other address keeps flag", 0, 0, 0, 8'h6A);
        rd_reg(6'h0D);
        expect_st("R6 watchdog flag cleared", 0, 0, 0, 8'h68);

        wr_reg(6'h0B, 8'h6C);
        fire(1'b1);
        expect_st("R10 masked alarm flag still sets", 0, 0, 0, 8'h6D);
        @(negedge clk);
        expect_st("R10 masked alarm keeps pins quiet", 0, 0, 0, 8'h6D);
        wr_reg(6'h07, 8'h00);
        expect_st("R7 alarm flag cleared by write", 0, 0, 0, 8'h6C);

        // Pulse mode, swap=0: watchdog on open-drain pin
        wr_reg(6'h0B, 8'h30);
        expect_st("R2 pulse config", 0, 0, 0, 8'h30);
        fire(1'b0);
        expect_st("R9 pulse not yet", 0, 0, 0, 8'h32);
        @(negedge clk);
        expect_st("R3 R9 pulse cycle 1 on open-drain pin", 1, 0, 0, 8'h32);
        @(negedge clk);
        expect_st("R9 pulse cycle 2", 1, 0, 0, 8'h32);
        wd_event = 1'b1;
        @(negedge clk);
        wd_event = 1'b0;
        expect_st("R9 pulse cycle 3", 1, 0, 0, 8'h32);
        @(negedge clk);
        expect_st("R9 pulse cycle 4", 1, 0, 0, 8'h32);
        @(negedge clk);
        expect_st("R9 pulse not extended", 0, 0, 0, 8'h32);
        @(negedge clk);
        expect_st("R9 no second pulse while flag set", 0, 0, 0, 8'h32);

        wr_reg(6'h0C, 8'h00);
        expect_st("R6 cleared by write at 0x0C", 0, 0, 0, 8'h30);
        fire(1'b0);
        expect_st("R9 re-armed flag", 0, 0, 0, 8'h32);
        @(negedge clk);
        expect_st("R9 new pulse after clear", 1, 0, 0, 8'h32);
        repeat (4) @(negedge clk);
        expect_st("R9 new pulse ended", 0, 0, 0, 8'h32);

        // Event wins over clearing access in the same cycle
        @(negedge clk);
        tod_event = 1'b1; reg_rd = 1'b1; reg_addr = 6'h03;
        @(negedge clk);
        tod_event = 1'b0; reg_rd = 1'b0; reg_addr = 6'h0B;
        expect_st("R5 event wins over clear", 0, 0, 0, 8'h33);
        @(negedge clk);
        expect_st("R3 R4 alarm pulse on INTB high", 0, 1, 1, 8'h33);
        repeat (4) @(negedge clk);
        expect_st("R9 INTB pulse ended", 0, 0, 0, 8'h33);

        done = 1'b1;
        summary();
    end

endmodule